// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Unit

This block moves one byte at a time over a three-wire synchronous serial link: a serial data output, a serial data input and one shift-clock pin shared by both directions. Because the clock line is shared, a transfer either sends or receives, never both at once. A transfer always takes exactly eight shift-clock cycles.

As clock master the unit makes the shift clock itself, dividing a selected internal timing source (presented as a one-cycle enable pulse, `srcTick`) by sixteen, and drives it on the clock pin. As clock slave it follows a clock driven onto the pin by the far side, brought in through a two-stage synchronizer. Software picks the bit order (bit 0 first or bit 7 first) and the clock polarity. The leading edge of each clock cycle, the one that leaves the idle level, samples the input; the trailing edge moves the output on to the next bit. While the serial function is not enabled, the data and clock pins carry plain general-purpose I/O values.

Top module: `clkSyncSerial`

## Requirements
- R1: Every transfer has exactly 8 leading and 8 trailing clock edges; at the eighth trailing edge the busy status drops and `xferDone` goes to 1, where it stays until the next accepted trigger or reset.
- R2: In master mode the shift-clock period is 16 `srcTick` pulses (8 pulses per half period), the clock pin is driven (`pinSclkOe`=1), and while idle the clock pin rests at `clkInvert` (0: idle low, leading edge rising; 1: idle high, leading edge falling).
- R3: In slave mode the unit never drives the clock pin (`pinSclkOe`=0) and counts edges of `sclkIn`, with the same polarity meaning as R2.
- R4: With `msbFirst`=0 the byte goes out and comes in bit 0 first; with `msbFirst`=1, bit 7 first. The first transmitted bit is on `pinSout` before the first leading edge.
- R5: Input is sampled on leading edges only and `pinSout` changes on trailing edges only; outside a transmission `pinSout` is 1.
- R6: Transmit and receive never run together; a transmit trigger and a receive trigger accepted in the same cycle start a transmission.
- R7: `rxBusy` reads 1 from the cycle after an accepted receive trigger until the reception ends, and 0 otherwise.
- R8: A trigger is accepted only when its own enable and `portEn` are 1 and no transfer is running; any other trigger has no effect.
- R9: With `portEn`=0 the pins follow the general-purpose values: bit 0 of `gpioOut`/`gpioOe` goes to the data-out pin, bit 1 to the clock pin. With `portEn`=1 the data-out pin is always driven.
- R10: Clearing the enable of the running direction, or `portEn`, ends the transfer at once: busy drops, `xferDone` stays 0, `rxData` keeps its value and a master clock returns to idle.
- R11: A synchronous active-low reset clears busy status, `xferDone`, the received byte, the shift register and the bit counter.
- R12: `rxData` changes only at the end of a completed reception; transmissions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| portEn | input | 1 | Gives the data and clock pins to the serial function |
| isMaster | input | 1 | 1: generate the shift clock; 0: follow `sclkIn` |
| msbFirst | input | 1 | Bit order select (1: bit 7 first) |
| clkInvert | input | 1 | Clock polarity (1: idle high) |
| srcTick | input | 1 | One-cycle pulse from the selected internal timing source |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| txTrig | input | 1 | Transmit start pulse |
| rxTrig | input | 1 | Receive start pulse |
| txData | input | 8 | Byte to send, taken when a transmission starts |
| rxData | output | 8 | Last byte received |
| txBusy | output | 1 | Transmission in progress |
| rxBusy | output | 1 | Reception in progress |
| xferDone | output | 1 | Sticky completion flag |
| gpioOut | input | 2 | General-purpose pin values (bit 0 data pin, bit 1 clock pin) |
| gpioOe | input | 2 | General-purpose output enables (same bit mapping) |
| sdIn | input | 1 | Serial data input pin |
| sclkIn | input | 1 | Clock pin input (slave mode) |
| pinSout | output | 1 | Data-out pin value |
| pinSoutOe | output | 1 | Data-out pin output enable |
| pinSclkOut | output | 1 | Clock pin value |
| pinSclkOe | output | 1 | Clock pin output enable |

## Verification
The bench goes after bytes with a single set bit at either end in both orders, where a reversed shift direction or an off-by-one first bit would swap or lose the marker bit. It fires a receive trigger during a transmission and both triggers in the same cycle, where a unit without the busy guard or the transmit priority would switch direction mid-byte or show both busy flags. It clears an enable and asserts reset partway through a byte, where a faulty design would keep clocking, raise the done flag or corrupt the received byte. It also measures the master clock period under several tick spacings and both polarities, so a wrong divider or a clock that idles at the wrong level shows up directly at the pins.

// File: rtl/cssPkg.sv
package cssPkg;
  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic start;   // accepted trigger: load shifter
    logic isTx;    // direction of the transfer being started or running
    logic msb;     // bit order of that transfer
    logic sample;  // leading edge: shift in one bit
    logic shift;   // trailing edge: present next output bit
    logic finish;  // last trailing edge of the byte
    logic abort;   // enable removed mid-transfer
  } cssStrobe_t;
endpackage

// File: rtl/cssSync.sv
module cssSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : gSingle
      logic r;
      always_ff @(posedge clk) begin
        if (!rstN) r <= 1'b0;
        else       r <= d;
      end
      assign q = r;
    end else begin : gChain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (!rstN) r <= '0;
        else       r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cssCtrl.sv
module cssCtrl import cssPkg::*; #(
  parameter int DATA_BITS = 8,
  parameter int CLK_DIV   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portEn,
  input  logic       isMaster,
  input  logic       msbFirst,
  input  logic       clkInvert,
  input  logic       srcTick,
  input  logic       txEn,
  input  logic       rxEn,
  input  logic       txTrig,
  input  logic       rxTrig,
  input  logic       sclkSync,
  output cssStrobe_t stb,
  output logic       txBusy,
  output logic       rxBusy,
  output logic       xferDone,
  output logic       sclkDrive,
  output logic       sclkLevel
);
  localparam int EDGES = 2 * DATA_BITS;
  localparam int CNT_W = $clog2(EDGES);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic             busyQ, dirTxQ, masterQ, invQ, msbQ, lvlQ, prevQ, doneQ;
  logic [CNT_W-1:0] edgeQ;
  logic [DIV_W-1:0] divQ;
  logic             txGo, rxGo, startW, abortW, mEdge, sEdge, edgeW;

  always_comb begin
    txGo   = txTrig & txEn;
    rxGo   = rxTrig & rxEn;
    startW = !busyQ && portEn && (txGo || rxGo);
    abortW = busyQ && (!portEn || (dirTxQ ? !txEn : !rxEn));
    mEdge  = busyQ && masterQ && srcTick && (divQ == DIV_W'(HALF - 1));
    sEdge  = busyQ && !masterQ && (sclkSync != prevQ);
    edgeW  = !abortW && (mEdge || sEdge);

    stb.start  = startW;
    stb.isTx   = busyQ ? dirTxQ : txGo;   // transmit wins a tie
    stb.msb    = busyQ ? msbQ : msbFirst;
    stb.sample = edgeW && !edgeQ[0];
    stb.shift  = edgeW && edgeQ[0];
    stb.finish = edgeW && (edgeQ == CNT_W'(EDGES - 1));
    stb.abort  = abortW;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0; dirTxQ <= 1'b0; masterQ <= 1'b0; invQ <= 1'b0;
      msbQ  <= 1'b0; lvlQ   <= 1'b0; prevQ   <= 1'b0; doneQ <= 1'b0;
      edgeQ <= '0;   divQ   <= '0;
    end else begin
      prevQ <= sclkSync;
      if (!busyQ) begin
        masterQ <= isMaster;
        invQ    <= clkInvert;
        msbQ    <= msbFirst;
      end
      if (startW) begin
        busyQ  <= 1'b1;
        dirTxQ <= txGo;
        doneQ  <= 1'b0;
        edgeQ  <= '0;
        divQ   <= '0;
        lvlQ   <= 1'b0;
      end else if (abortW) begin
        busyQ <= 1'b0;
        lvlQ  <= 1'b0;
      end else if (busyQ) begin
        if (masterQ && srcTick)
          divQ <= (divQ == DIV_W'(HALF - 1)) ? '0 : divQ + DIV_W'(1);
        if (edgeW) begin
          lvlQ  <= ~lvlQ;
          edgeQ <= edgeQ + CNT_W'(1);
        end
        if (stb.finish) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
          edgeQ <= '0;
        end
      end
    end
  end

  assign txBusy    = busyQ & dirTxQ;
  assign rxBusy    = busyQ & ~dirTxQ;
  assign xferDone  = doneQ;
  assign sclkDrive = masterQ;
  assign sclkLevel = lvlQ ^ invQ;

  // R1
  finish_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (!busyQ && doneQ));
  // R2
  master_idle_lvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && masterQ) |-> !lvlQ);
  // R8
  busy_ignores_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !abortW && !stb.finish) |=> (busyQ && $stable(dirTxQ)));
  // R10
  abort_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortW |=> (!busyQ && !doneQ && !lvlQ));
endmodule

// File: rtl/cssDatapath.sv
module cssDatapath import cssPkg::*; #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cssStrobe_t           stb,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 sdSync,
  output logic                 soutBit,
  output logic [DATA_BITS-1:0] rxData
);
  localparam int TOP = DATA_BITS - 1;

  logic [DATA_BITS-1:0] sregQ, rxQ;
  logic                 outQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sregQ <= '0;
      rxQ   <= '0;
      outQ  <= 1'b1;
    end else if (stb.start) begin
      sregQ <= stb.isTx ? txData : '0;
      outQ  <= stb.msb ? txData[TOP] : txData[0];
    end else begin
      if (stb.sample)
        sregQ <= stb.msb ? {sregQ[TOP-1:0], sdSync} : {sdSync, sregQ[TOP:1]};
      if (stb.shift)
        outQ <= stb.msb ? sregQ[TOP] : sregQ[0];
      if (stb.finish && !stb.isTx)
        rxQ <= sregQ;
    end
  end

  assign soutBit = outQ;
  assign rxData  = rxQ;

  // R5
  sout_hold_on_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && !stb.start) |=> $stable(outQ));
  // R12
  rx_only_on_rx_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.finish && !stb.isTx) |=> $stable(rxQ));
  // R10
  rx_kept_on_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.abort |=> $stable(rxQ));
endmodule

// File: rtl/clkSyncSerial.sv
module clkSyncSerial import cssPkg::*; #(
  parameter int DATA_BITS   = 8,
  parameter int CLK_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 portEn,
  input  logic                 isMaster,
  input  logic                 msbFirst,
  input  logic                 clkInvert,
  input  logic                 srcTick,
  input  logic                 txEn,
  input  logic                 rxEn,
  input  logic                 txTrig,
  input  logic                 rxTrig,
  input  logic [DATA_BITS-1:0] txData,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 txBusy,
  output logic                 rxBusy,
  output logic                 xferDone,
  input  logic [1:0]           gpioOut,
  input  logic [1:0]           gpioOe,
  input  logic                 sdIn,
  input  logic                 sclkIn,
  output logic                 pinSout,
  output logic                 pinSoutOe,
  output logic                 pinSclkOut,
  output logic                 pinSclkOe
);
  cssStrobe_t stb;
  logic sclkSync, sdSync, soutBit, sclkDrive, sclkLevel;

  cssSync #(.STAGES(SYNC_STAGES)) uSyncClk (
    .clk(clk), .rstN(rstN), .d(sclkIn), .q(sclkSync));
  cssSync #(.STAGES(SYNC_STAGES)) uSyncDat (
    .clk(clk), .rstN(rstN), .d(sdIn), .q(sdSync));

  cssCtrl #(.DATA_BITS(DATA_BITS), .CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .isMaster(isMaster),
    .msbFirst(msbFirst), .clkInvert(clkInvert), .srcTick(srcTick),
    .txEn(txEn), .rxEn(rxEn), .txTrig(txTrig), .rxTrig(rxTrig),
    .sclkSync(sclkSync), .stb(stb), .txBusy(txBusy), .rxBusy(rxBusy),
    .xferDone(xferDone), .sclkDrive(sclkDrive), .sclkLevel(sclkLevel));

  cssDatapath #(.DATA_BITS(DATA_BITS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData), .sdSync(sdSync),
    .soutBit(soutBit), .rxData(rxData));

  // pin routing: serial function or general-purpose values
  always_comb begin
    if (portEn) begin
      pinSout    = txBusy ? soutBit : 1'b1;
      pinSoutOe  = 1'b1;
      pinSclkOut = sclkLevel;
      pinSclkOe  = sclkDrive;
    end else begin
      pinSout    = gpioOut[0];
      pinSoutOe  = gpioOe[0];
      pinSclkOut = gpioOut[1];
      pinSclkOe  = gpioOe[1];
    end
  end

  // R6
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txTrig && txEn && rxTrig && rxEn && portEn && !txBusy && !rxBusy) |=> (txBusy && !rxBusy));
endmodule

// File: tb/clkSyncSerial_test.sv
module clkSyncSerial_test;
  logic clk = 0, rstN = 0;
  logic portEn = 0, isMaster = 0, msbFirst = 0, clkInvert = 0, srcTick = 0;
  logic txEn = 0, rxEn = 0, txTrig = 0, rxTrig = 0;
  logic [7:0] txData = 0, rxData;
  logic txBusy, rxBusy, xferDone;
  logic [1:0] gpioOut = 0, gpioOe = 0;
  logic sdIn = 1, sclkIn = 0;
  logic pinSout, pinSoutOe, pinSclkOut, pinSclkOe;

  int total = 0, fails = 0, tickGap = 1, tickCnt = 0;
  bit finished = 0;

  clkSyncSerial uut (.*);

  always #10 clk = ~clk;   // 50 MHz

  always @(negedge clk) begin
    if (tickCnt >= tickGap - 1) begin tickCnt <= 0; srcTick <= 1'b1; end
    else begin tickCnt <= tickCnt + 1; srcTick <= 1'b0; end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic bitOf(logic [7:0] b, int i, bit msb);
    return msb ? b[7-i] : b[i];
  endfunction

  function automatic logic [7:0] addBit(logic [7:0] c, logic b, bit msb);
    return msb ? {c[6:0], b} : {b, c[7:1]};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTrig(bit tx, bit rx);
    @(negedge clk); txTrig = tx; rxTrig = rx;
    @(negedge clk); txTrig = 0; rxTrig = 0;
  endtask

  task automatic runMaster(bit tx, bit msb, bit inv, logic [7:0] txB, logic [7:0] rxB, int gap);
    logic [7:0] cap = 0, prevRx;
    int lead = 0, trail = 0, n = 0, firstLead = 0, period = 0;
    logic lvl, prevN = 0;
    tickGap = gap; isMaster = 1; msbFirst = msb; clkInvert = inv;
    txEn = tx; rxEn = !tx; txData = txB; portEn = 1;
    cyc(3);
    chk("R2 idle clock level", pinSclkOut, inv);
    chk("R2 clock pin driven", pinSclkOe, 1);
    chk("R5 sout idle high", pinSout, 1);
    prevRx = rxData;
    sdIn = bitOf(rxB, 0, msb);
    pulseTrig(tx, !tx);
    if (tx) chk("R6 txBusy after trigger", {txBusy, rxBusy}, 2'b10);
    else    chk("R7 rxBusy after trigger", {txBusy, rxBusy}, 2'b01);
    if (tx) chk("R4 first bit before leading edge", pinSout, bitOf(txB, 0, msb));
    while (trail < 8 && n < 4000) begin
      @(negedge clk); n++;
      lvl = pinSclkOut ^ inv;
      if (lvl && !prevN) begin
        cap = addBit(cap, pinSout, msb);
        if (lead == 0) firstLead = n;
        if (lead == 1) period = n - firstLead;
        lead++;
      end
      if (!lvl && prevN) begin
        trail++;
        if (trail < 8) sdIn = bitOf(rxB, trail, msb);
      end
      prevN = lvl;
    end
    chk("R1 leading edge count", lead, 8);
    chk("R1 busy cleared at end", {txBusy, rxBusy}, 0);
    chk("R1 done flag set", xferDone, 1);
    chk("R2 master period", period, 16 * gap);
    if (tx) begin
      chk("R4 transmitted byte", cap, txB);
      chk("R12 rxData unchanged by transmit", rxData, prevRx);
    end else begin
      chk("R4 received byte", rxData, rxB);
      chk("R7 rxBusy low after reception", rxBusy, 0);
    end
  endtask

  task automatic runSlave(bit tx, bit msb, bit inv, logic [7:0] txB, logic [7:0] rxB);
    logic [7:0] cap = 0;
    isMaster = 0; msbFirst = msb; clkInvert = inv; sclkIn = inv;
    txEn = tx; rxEn = !tx; txData = txB; portEn = 1;
    cyc(4);
    chk("R3 slave leaves clock pin undriven", pinSclkOe, 0);
    sdIn = bitOf(rxB, 0, msb);
    pulseTrig(tx, !tx);
    chk("R3 slave transfer started", txBusy | rxBusy, 1);
    for (int i = 0; i < 8; i++) begin
      cyc(6);
      cap = addBit(cap, pinSout, msb);
      sclkIn = ~inv;
      cyc(6);
      if (i == 3) chk("R1 no done mid-byte", xferDone, 0);
      sclkIn = inv;
      if (i < 7) sdIn = bitOf(rxB, i + 1, msb);
    end
    cyc(5);
    chk("R1 slave done", {xferDone, txBusy, rxBusy}, 3'b100);
    if (tx) chk("R5 slave transmitted byte", cap, txB);
    else    chk("R3 slave received byte", rxData, rxB);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] keep;
    int dummy;
    dummy = $urandom(32'd7177);
    cyc(3);
    chk("R11 reset busy", {txBusy, rxBusy, xferDone}, 0);
    chk("R11 reset rxData", rxData, 0);
    @(negedge clk); rstN = 1;

    // R9 pin routing with serial function off
    portEn = 0;
    for (int k = 0; k < 4; k++) begin
      gpioOut = 2'($urandom()); gpioOe = 2'($urandom());
      cyc(1);
      chk("R9 gpio routing", {pinSclkOe, pinSclkOut, pinSoutOe, pinSout},
          {gpioOe[1], gpioOut[1], gpioOe[0], gpioOut[0]});
    end
    // R8 trigger ignored with portEn low
    txEn = 1; rxEn = 1;
    pulseTrig(1, 1);
    chk("R8 trigger ignored when port disabled", {txBusy, rxBusy}, 0);

    // directed single-bit corner bytes, both orders
    runMaster(1, 1, 0, 8'h01, 8'h00, 1);
    runMaster(1, 0, 1, 8'h80, 8'h00, 1);
    runMaster(0, 1, 0, 8'h00, 8'h01, 2);
    runMaster(0, 0, 1, 8'h00, 8'h80, 1);

    // random master and slave transfers
    for (int k = 0; k < 6; k++)
      runMaster(1'($urandom()), 1'($urandom()), 1'($urandom()),
                8'($urandom()), 8'($urandom()), 1 + int'($urandom() % 3));
    for (int k = 0; k < 4; k++)
      runSlave(1'($urandom()), 1'($urandom()), 1'($urandom()),
               8'($urandom()), 8'($urandom()));
    runSlave(1, 0, 1, 8'h80, 8'h00);
    runSlave(0, 1, 0, 8'h00, 8'h01);

    // R8 trigger without its enable
    isMaster = 1; clkInvert = 0; tickGap = 1; txEn = 0; rxEn = 0;
    pulseTrig(1, 1);
    chk("R8 trigger ignored without enable", {txBusy, rxBusy}, 0);

    // R8 receive trigger during a transmission
    txEn = 1; txData = 8'h5A;
    pulseTrig(1, 0);
    cyc(20);
    rxEn = 1;
    pulseTrig(0, 1);
    chk("R8 trigger while busy ignored", {txBusy, rxBusy}, 2'b10);
    for (int k = 0; k < 400 && txBusy; k++) cyc(1);
    chk("R1 transmission completes", {xferDone, txBusy}, 2'b10);

    // R6 simultaneous triggers: transmit wins
    txEn = 1; rxEn = 1;
    pulseTrig(1, 1);
    chk("R6 tie goes to transmit", {txBusy, rxBusy}, 2'b10);
    txEn = 0;
    cyc(2);
    chk("R10 tx abort clears busy", {xferDone, txBusy}, 0);

    // R10 receive abort partway through
    keep = rxData; sdIn = 1; rxEn = 1;
    pulseTrig(0, 1);
    cyc(40);
    rxEn = 0;
    cyc(2);
    chk("R10 abort state", {xferDone, rxBusy, pinSclkOut}, 0);
    chk("R10 rxData kept after abort", rxData, keep);

    // R11 reset mid-transfer
    rxEn = 1;
    pulseTrig(0, 1);
    cyc(30);
    rstN = 0;
    cyc(1);
    rstN = 1;
    chk("R11 reset clears busy and done", {xferDone, txBusy, rxBusy}, 0);
    chk("R11 reset clears rxData", rxData, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule